// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block sits between a memory request source and a single DRAM bank. It accepts one request at a time, each naming a row, a column and whether it reads or writes. It turns the request into the command steps the bank needs: closing a previously opened row, opening the requested row into the sense amplifiers, and performing the column access. Row and column addresses share one address bus and are driven in different cycles.

The sequencer leaves a row open after each access. A later request to the same row therefore costs only a column command. A request to a different row first closes the current row, then opens the new one. Three parameterised wait counters hold off each command until the bank is ready for it. The block raises a done strobe when the access is complete, together with a read-data-valid strobe for reads.

Top module: `bank_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `cmd_o` is NOP, `addr_o` is 0, `done_o` and `rd_valid_o` are 0, and no row counts as open.
- R2: When no row is open, an accepted request issues ACT with the request row on `addr_o` in the first cycle after acceptance, with no PRE before it.
- R3: The column command follows its ACT by exactly `T_RCD` cycles, and no column command comes earlier than `T_RCD` cycles after the latest ACT.
- R4: `done_o` rises exactly `T_CL` cycles after the column command, for reads and for writes.
- R5: ACT follows a PRE by exactly `T_RP` cycles, and never fewer.
- R6: A request whose row equals the open row issues its column command in the first cycle after acceptance, with no PRE and no ACT.
- R7: A request to a row other than the open row issues PRE in the first cycle after acceptance, then ACT of the new row, then the column command.
- R8: `req_ready` is 0 from the cycle after acceptance through the cycle of `done_o`, and is 1 again in the next cycle. While `req_ready` is 1, `cmd_o` is NOP.
- R9: `rd_valid_o` is 1 only in the `done_o` cycle of a read. A write completes with `rd_valid_o` at 0.
- R10: `cmd_o` encodes NOP=0, ACT=1, RD=2, WR=3, PRE=4. `addr_o` carries the row on ACT and the zero-extended column on RD or WR, and is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and taking a request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | Column of the request |
| cmd_o | output | 3 | Bank command (NOP=0, ACT=1, RD=2, WR=3, PRE=4) |
| addr_o | output | max(ROW_W,COL_W) | Shared row/column address |
| rd_valid_o | output | 1 | Read data valid at the bank pins |
| done_o | output | 1 | Access complete |

## Verification
The bench sends a sequence of requests that covers the three row cases: no row open, same row and a different row. It also includes the extreme row values 0 and all-ones, and a reset in the middle of the sequence that must close the open row. It measures the cycle offset of every command and of done from the acceptance edge against arithmetic built from distinct `T_RP`, `T_RCD` and `T_CL` values. A design that mixed up two counters, reissued ACT on a row hit, skipped the precharge on a row change, or kept the old row open across reset would show a wrong offset or an unexpected command. A design that put the column on the bus with the wrong command, left the address non-zero on idle cycles, or flagged read data on writes would fail the bus and strobe checks.

// File: rtl/bank_seq_pkg.sv
package bank_seq_pkg;
   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_RD  = 3'd2,
      CMD_WR  = 3'd3,
      CMD_PRE = 3'd4
   } bank_cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_ACT,
      ST_COL,
      ST_DATA
   } seq_state_e;

   // timer slots
   localparam int unsigned TMR_RP  = 0;
   localparam int unsigned TMR_RCD = 1;
   localparam int unsigned TMR_CL  = 2;
   localparam int unsigned TMR_N   = 3;
endpackage

// File: rtl/bank_gap_timer.sv
// Down counter guarding one inter-command gap. Loaded with GAP-1 in the
// command cycle, so "expired" is true again exactly GAP cycles later.
module bank_gap_timer #(
   parameter int unsigned GAP = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expired
);
   localparam int unsigned CW = (GAP < 2) ? 1 : $clog2(GAP + 1);

   if (GAP < 1) begin : g_bad_gap
      $error("bank_gap_timer: GAP must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= CW'(GAP - 1);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   // R3: a gap is only restarted once the previous one has run out
   p_reload_expired_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> expired);
endmodule

// File: rtl/bank_row_track.sv
// Remembers which row is latched in the sense amplifiers.
module bank_row_track #(
   parameter int unsigned ROW_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_set,
   input  logic             close,
   input  logic [ROW_W-1:0] set_row,
   input  logic [ROW_W-1:0] probe_row,
   output logic             is_open,
   output logic             hit
);
   logic [ROW_W-1:0] row_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         is_open <= 1'b0;
         row_q   <= '0;
      end else if (close) begin
         is_open <= 1'b0;
      end else if (open_set) begin
         is_open <= 1'b1;
         row_q   <= set_row;
      end
   end

   assign hit = is_open && (row_q == probe_row);

   // R7: a row is only opened once the bank holds no open row
   p_act_on_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      open_set |-> !is_open);
   // R7: close and open never coincide
   p_set_close_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(open_set && close));
endmodule

// File: rtl/bank_seq.sv
module bank_seq
   import bank_seq_pkg::*;
#(
   parameter int unsigned ROW_W = 12,
   parameter int unsigned COL_W = 8,
   parameter int unsigned T_RCD = 3,
   parameter int unsigned T_CL  = 2,
   parameter int unsigned T_RP  = 4,
   localparam int unsigned ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   output logic [2:0]        cmd_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              rd_valid_o,
   output logic              done_o
);
   localparam int unsigned GAPS [TMR_N] = '{T_RP, T_RCD, T_CL};
   localparam int unsigned SINCE_W = 16;

   if (ROW_W < 1 || COL_W < 1) begin : g_bad_width
      $error("bank_seq: address widths must be at least 1");
   end
   if (T_RCD < 1 || T_CL < 1 || T_RP < 1) begin : g_bad_gap
      $error("bank_seq: every gap must be at least one cycle");
   end
   if (T_RCD > 1000 || T_CL > 1000 || T_RP > 1000) begin : g_big_gap
      $error("bank_seq: gaps above 1000 cycles are not supported");
   end

   seq_state_e       state_q, state_d;
   bank_cmd_e        cmd;
   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] col_q;
   logic             wr_q;
   logic [TMR_N-1:0] tload, texp;
   logic             act_fire, pre_fire;
   logic             row_open, row_hit;
   logic             accept;

   for (genvar g = 0; g < TMR_N; g++) begin : g_tmr
      bank_gap_timer #(.GAP(GAPS[g])) i_tmr (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (tload[g]),
         .expired (texp[g])
      );
   end

   bank_row_track #(.ROW_W(ROW_W)) i_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .open_set  (act_fire),
      .close     (pre_fire),
      .set_row   (row_q),
      .probe_row (req_row),
      .is_open   (row_open),
      .hit       (row_hit)
   );

   assign accept = req_ready && req_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         row_q   <= '0;
         col_q   <= '0;
         wr_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            row_q <= req_row;
            col_q <= req_col;
            wr_q  <= req_write;
         end
      end
   end

   always_comb begin
      state_d    = state_q;
      cmd        = CMD_NOP;
      addr_o     = '0;
      tload      = '0;
      act_fire   = 1'b0;
      pre_fire   = 1'b0;
      req_ready  = 1'b0;
      rd_valid_o = 1'b0;
      done_o     = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            req_ready = 1'b1;
            if (req_valid)
               state_d = !row_open ? ST_ACT : (row_hit ? ST_COL : ST_PRE);
         end
         ST_PRE: begin
            cmd            = CMD_PRE;
            tload[TMR_RP]  = 1'b1;
            pre_fire       = 1'b1;
            state_d        = ST_ACT;
         end
         ST_ACT: begin
            if (texp[TMR_RP]) begin
               cmd            = CMD_ACT;
               addr_o         = ADDR_W'(row_q);
               tload[TMR_RCD] = 1'b1;
               act_fire       = 1'b1;
               state_d        = ST_COL;
            end
         end
         ST_COL: begin
            if (texp[TMR_RCD]) begin
               cmd           = wr_q ? CMD_WR : CMD_RD;
               addr_o        = ADDR_W'(col_q);
               tload[TMR_CL] = 1'b1;
               state_d       = ST_DATA;
            end
         end
         ST_DATA: begin
            if (texp[TMR_CL]) begin
               done_o     = 1'b1;
               rd_valid_o = !wr_q;
               state_d    = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   assign cmd_o = cmd;

   // ---------------- assertion support: cycles since each command --------
   logic [SINCE_W-1:0] since_act, since_pre, since_col;
   logic               is_col;

   assign is_col = (cmd_o == CMD_RD) || (cmd_o == CMD_WR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_act <= '1;
         since_pre <= '1;
         since_col <= '1;
      end else begin
         if (cmd_o == CMD_ACT)     since_act <= SINCE_W'(1);
         else if (since_act != '1) since_act <= since_act + 1'b1;
         if (cmd_o == CMD_PRE)     since_pre <= SINCE_W'(1);
         else if (since_pre != '1) since_pre <= since_pre + 1'b1;
         if (is_col)               since_col <= SINCE_W'(1);
         else if (since_col != '1) since_col <= since_col + 1'b1;
      end
   end

   p_rcd_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      is_col |-> (since_act >= SINCE_W'(T_RCD)));
   p_cl_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (since_col == SINCE_W'(T_CL)));
   p_rp_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == CMD_ACT) |-> (since_pre >= SINCE_W'(T_RP)));
   p_hit_col_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && row_hit) |=> is_col);
   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (cmd_o == CMD_NOP));
   p_rdv_in_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> (done_o && !wr_q));
   p_nop_addr_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd_o == CMD_NOP) || (cmd_o == CMD_PRE)) |-> (addr_o == '0));
endmodule

// File: tb/test_bank_seq.sv
module test_bank_seq;
   localparam int unsigned ROW_W = 12;
   localparam int unsigned COL_W = 8;
   localparam int unsigned T_RCD = 3;
   localparam int unsigned T_CL  = 2;
   localparam int unsigned T_RP  = 4;
   localparam int unsigned ADDR_W = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic              req_write = 1'b0;
   logic [ROW_W-1:0]  req_row = '0;
   logic [COL_W-1:0]  req_col = '0;
   logic [2:0]        cmd_o;
   logic [ADDR_W-1:0] addr_o;
   logic              rd_valid_o;
   logic              done_o;

   int checks = 0;
   int errors = 0;
   bit m_open = 1'b0;
   int m_row = 0;

   always #5 clk = ~clk;

   bank_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD), .T_CL(T_CL), .T_RP(T_RP))
   i_bank_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_row(req_row), .req_col(req_col),
      .cmd_o(cmd_o), .addr_o(addr_o), .rd_valid_o(rd_valid_o), .done_o(done_o)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      req_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      m_open = 1'b0;
      @(negedge clk);
      chk("R1", "ready after reset", int'(req_ready), 1);
      chk("R1", "cmd after reset", int'(cmd_o), 0);
      chk("R1", "addr after reset", int'(addr_o), 0);
      chk("R1", "done after reset", int'(done_o), 0);
      chk("R1", "rd_valid after reset", int'(rd_valid_o), 0);
   endtask

   // Called at a negedge with the sequencer idle.
   task automatic run_req(input int row, input int col, input bit wr);
      int kind, t, ncmd;
      int t_pre, t_act, t_col, t_done;
      int e_pre, e_act, e_col, e_done, e_ncmd;
      string tg;
      kind = !m_open ? 0 : ((m_row == row) ? 1 : 2);
      case (kind)
         0: begin e_pre = -1; e_act = 1; e_col = 1 + T_RCD; tg = "R2"; end
         1: begin e_pre = -1; e_act = -1; e_col = 1; tg = "R6"; end
         default: begin e_pre = 1; e_act = 1 + T_RP; e_col = 1 + T_RP + T_RCD; tg = "R7"; end
      endcase
      e_done = e_col + T_CL;
      e_ncmd = (e_pre > 0 ? 1 : 0) + (e_act > 0 ? 1 : 0) + 1;

      chk("R8", "ready before request", int'(req_ready), 1);
      req_valid = 1'b1;
      req_row = ROW_W'(row);
      req_col = COL_W'(col);
      req_write = wr;
      @(negedge clk);
      req_valid = 1'b0;
      t = 1; ncmd = 0;
      t_pre = -1; t_act = -1; t_col = -1; t_done = -1;
      while (t_done < 0 && t < 200) begin
         case (cmd_o)
            3'd4: begin t_pre = t; ncmd++; chk("R10", "addr on PRE", int'(addr_o), 0); end
            3'd1: begin t_act = t; ncmd++; chk("R10", "row on ACT", int'(addr_o), row); end
            3'd2, 3'd3: begin
               t_col = t; ncmd++;
               chk("R10", "column cmd code", int'(cmd_o), wr ? 3 : 2);
               chk("R10", "column on bus", int'(addr_o), col);
            end
            3'd0: chk("R10", "addr on NOP", int'(addr_o), 0);
            default: chk("R10", "illegal cmd", int'(cmd_o), 0);
         endcase
         if (done_o) begin
            t_done = t;
            chk("R9", "rd_valid at done", int'(rd_valid_o), wr ? 0 : 1);
         end else begin
            chk("R9", "rd_valid outside done", int'(rd_valid_o), 0);
         end
         chk("R8", "ready while busy", int'(req_ready), 0);
         @(negedge clk);
         t++;
      end
      chk(tg, "PRE offset", t_pre, e_pre);
      chk(kind == 2 ? "R5" : tg, "ACT offset", t_act, e_act);
      chk(kind == 1 ? "R6" : "R3", "column offset", t_col, e_col);
      chk("R4", "done offset", t_done, e_done);
      chk(tg, "command count", ncmd, e_ncmd);
      chk("R8", "ready after done", int'(req_ready), 1);
      m_open = 1'b1;
      m_row = row;
   endtask

   initial begin
      int rows [9] = '{7, 7, 7, 12, 12, 4095, 0, 0, 7};
      do_reset();
      for (int i = 0; i < 9; i++)
         run_req(rows[i], (i * 37 + 3) % 256, bit'((i / 2) % 2));
      // mid-run reset must forget the open row (R1, R2)
      do_reset();
      run_req(7, 255, 1'b0);
      run_req(7, 0, 1'b1);
      for (int i = 0; i < 16; i++)
         run_req(((i * 5) % 3) * 1000 + 1, (i * 91) % 256, bit'(i % 2));
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule